// File: doc/BRIEF.md
# Transmit Descriptor Processing Engine

This block is the transmit-side controller of a MAC DMA. While it is running, it walks a list of four-word descriptors in memory and checks each descriptor's ownership flag. It streams the buffer that each descriptor points to into a transmit FIFO and marks the first and last word of every frame. It closes the descriptors of a frame when it is done with them. The list can be a ring, where descriptors sit back to back and an end-of-ring flag returns the walk to the base address, or a chain, where each descriptor carries a link to the next one. The mode is chosen per descriptor.

Up to two frames can have been copied without their transmit status having come back yet. When the transmit path reports a finished frame, the engine writes the status into that frame's last descriptor and then hands the descriptor back to software. The engine suspends and raises an interrupt in two cases: when it meets a descriptor that software still owns, and when it finds a malformed descriptor. A poll demand makes it retry at the descriptor where it stopped.

Memory is word addressed and is reached through a single request/grant port. Read data is valid in the cycle the grant is given. Descriptor layout, at offsets from the descriptor address:

- word 0: bit 31 is ownership (1 = engine) and bits 15:0 hold the status.
- word 1: control. Bit 30 marks the first buffer of a frame, bit 29 the last buffer, bit 25 the end of the ring and bit 24 that the link is to be followed. Bits 10:0 give the buffer length in words.
- word 2: the buffer address.
- word 3: the link address.

States and transitions:

- IDLE goes to NEXT when `run` is high; the base address is latched at that point.
- NEXT does one of three things. If a status is pending and a frame is outstanding, it goes to STAT1. If two frames are outstanding, it waits in NEXT. Otherwise it goes to FETCH.
- FETCH reads words 0 to 3 of the current descriptor. If word 0 shows that software owns it, FETCH goes to SUSP. Otherwise, after word 3, it goes to CHECK.
- CHECK goes to SUSP on an error. Otherwise it goes to COPY.
- COPY reads the buffer into the FIFO. After the last word it goes to NEXT if the descriptor ends a frame, and to CLOSE if it does not.
- CLOSE writes word 0 to zero, then goes to NEXT.
- STAT1 writes the status with ownership still set, then goes to STAT2.
- STAT2 writes the status with ownership cleared, then returns to NEXT or to SUSP.
- SUSP goes to STAT1 when a status is pending. It goes to NEXT on `poll_demand`.

Top module: `txd_engine`

## Requirements
- R1: During and after reset, with `run` low, `mem_req`, `fifo_wr` and `irq` stay low.
- R2: When `run` goes high, the first descriptor fetched is at `list_base`, and its words are read at offsets 0 to 3.
- R3: If word 0 of a descriptor has bit 31 clear, the engine stops reading and raises `irq` with `irq_cause_err` = 0.
- R4: The engine copies the buffer's words to the FIFO in address order. `fifo_sof` marks the first word of a buffer that starts a frame (control bit 30), and `fifo_eof` marks the last word of a buffer that ends a frame (control bit 29).
- R5: A descriptor that does not end a frame is closed right after its buffer has been copied, by writing 0 to its word 0.
- R6: Without the link flag, the next descriptor is at the current address plus 4. If end-of-ring (control bit 25) is set, the next descriptor is at the base address instead.
- R7: With the link flag (control bit 24) set, the next descriptor is at the address held in word 3.
- R8: Three conditions are errors: a frame-start descriptor that lacks bit 30, a descriptor inside a frame that has bit 30 set, and a length of 0. Each one raises `irq` with `irq_cause_err` = 1, and no data is copied for that descriptor.
- R9: A second frame is copied before the first frame's status has returned. No third descriptor is fetched while two frames await status.
- R10: For each `tx_done` pulse, the last descriptor of the oldest outstanding frame receives two writes to its word 0: first the status with bit 31 set, then the same status with bit 31 clear.
- R11: In the suspended state, `poll_demand` makes the engine fetch the same descriptor again.
- R12: While `fifo_full` is high, no buffer word is read and nothing is pushed.
- R13: Status write-back also takes place while the engine is suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Starts the engine from idle |
| list_base | input | AW | Address of the first descriptor and the ring base |
| poll_demand | input | 1 | Resumes the engine from the suspended state |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid together with the grant |
| fifo_full | input | 1 | Transmit FIFO cannot accept a word |
| fifo_wr | output | 1 | Push a word into the FIFO |
| fifo_data | output | 32 | Word pushed |
| fifo_sof | output | 1 | Word is the first of a frame |
| fifo_eof | output | 1 | Word is the last of a frame |
| tx_done | input | 1 | Pulse: the oldest frame has been transmitted |
| tx_status | input | STATW | Status of that frame |
| irq | output | 1 | Engine is suspended |
| irq_cause_err | output | 1 | 1 = error, 0 = host-owned descriptor |

## Verification
FIFO pushes happen in the cycle the buffer read is granted. `irq` rises one clock after the granted word-0 read that shows host ownership, and one clock after the CHECK cycle that finds an error. Status write-back starts two clocks after `tx_done` at the earliest, and its two writes run back to back when each is granted at once. The bench therefore logs every granted memory access and every FIFO push at the clock edge. It compares the logs and the memory contents only after the event that ends a scenario, such as `irq` rising or a fixed settle time that is well beyond these latencies. It samples at the falling edge, so the exact cycle of each result never decides a check.

// File: rtl/txd_pkg.sv
package txd_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int OWN_BIT    = 31;
    localparam int SOF_BIT    = 30;
    localparam int EOF_BIT    = 29;
    localparam int EOR_BIT    = 25;
    localparam int LNK_BIT    = 24;

    typedef enum logic [3:0] {
        S_IDLE, S_NEXT, S_FETCH, S_CHECK, S_COPY,
        S_CLOSE, S_STAT1, S_STAT2, S_SUSP
    } state_t;

    typedef struct packed {
        logic sof;
        logic eof;
        logic eor;
        logic lnk;
    } ctl_t;
endpackage

// File: rtl/txd_nextptr.sv
module txd_nextptr
    import txd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] link,
    input  ctl_t          ctl,
    output logic [AW-1:0] nxt
);
    always_comb begin
        if (ctl.lnk)      nxt = link;
        else if (ctl.eor) nxt = base;
        else              nxt = cur + AW'(DESC_WORDS);
    end
endmodule

// File: rtl/txd_inflight.sv
module txd_inflight #(
    parameter int AW    = 16,
    parameter int SLOTS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic [AW-1:0] head,
    output logic [$clog2(SLOTS+1)-1:0] count,
    output logic          full
);
    localparam int CW = $clog2(SLOTS+1);

    logic [AW-1:0] slot_q [SLOTS];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] wr_idx;

    assign wr_idx = cnt_q - CW'(pop);
    assign head   = slot_q[0];
    assign count  = cnt_q;
    assign full   = (cnt_q == CW'(SLOTS));

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < SLOTS-1) begin : g_mid
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          slot_q[g] <= '0;
                else if (push && wr_idx == CW'(g))   slot_q[g] <= push_addr;
                else if (pop)                        slot_q[g] <= slot_q[g+1];
            end
        end else begin : g_last
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          slot_q[g] <= '0;
                else if (push && wr_idx == CW'(g))   slot_q[g] <= push_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(SLOTS));
    a_r10_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt_q != '0);
endmodule

// File: rtl/txd_engine.sv
module txd_engine
    import txd_pkg::*;
#(
    parameter int AW    = 16,
    parameter int LENW  = 11,
    parameter int STATW = 16,
    parameter int SLOTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [AW-1:0]     list_base,
    input  logic              poll_demand,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [WORD_W-1:0] fifo_data,
    output logic              fifo_sof,
    output logic              fifo_eof,
    input  logic              tx_done,
    input  logic [STATW-1:0]  tx_status,
    output logic              irq,
    output logic              irq_cause_err
);
    localparam int CW   = $clog2(SLOTS+1);
    localparam int PADW = WORD_W - 1 - STATW;

    state_t st, st_nx;
    logic [AW-1:0]    cur_q, base_q, buf_q, link_q, nxt_ptr, head;
    logic [1:0]       widx_q;
    ctl_t             ctl_q;
    logic [LENW-1:0]  len_q, left_q;
    logic             in_frame_q, first_q, done_pend_q, ret_susp_q, cause_q;
    logic [STATW-1:0] stat_q;
    logic [CW-1:0]    cnt;
    logic             full, acc, last_word, chk_err, push, pop, stat_due;

    assign acc       = mem_req && mem_gnt;
    assign last_word = (left_q == LENW'(1));
    assign chk_err   = (!in_frame_q && !ctl_q.sof) || (in_frame_q && ctl_q.sof)
                       || (len_q == '0);
    assign stat_due  = done_pend_q && (cnt != '0);
    assign push      = (st == S_COPY) && acc && last_word && ctl_q.eof;
    assign pop       = (st == S_STAT2) && acc;

    txd_nextptr #(.AW(AW)) u_nextptr (
        .cur(cur_q), .base(base_q), .link(link_q), .ctl(ctl_q), .nxt(nxt_ptr));

    txd_inflight #(.AW(AW), .SLOTS(SLOTS)) u_inflight (
        .clk(clk), .rst_n(rst_n), .push(push), .push_addr(cur_q), .pop(pop),
        .head(head), .count(cnt), .full(full));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:  if (run) st_nx = S_NEXT;
            S_NEXT:  if (stat_due)   st_nx = S_STAT1;
                     else if (!full) st_nx = S_FETCH;
            S_FETCH: if (acc) begin
                         if (widx_q == 2'd0 && !mem_rdata[OWN_BIT]) st_nx = S_SUSP;
                         else if (widx_q == 2'd3)                   st_nx = S_CHECK;
                     end
            S_CHECK: st_nx = chk_err ? S_SUSP : S_COPY;
            S_COPY:  if (acc && last_word) st_nx = ctl_q.eof ? S_NEXT : S_CLOSE;
            S_CLOSE: if (acc) st_nx = S_NEXT;
            S_STAT1: if (acc) st_nx = S_STAT2;
            S_STAT2: if (acc) st_nx = ret_susp_q ? S_SUSP : S_NEXT;
            S_SUSP:  if (stat_due)         st_nx = S_STAT1;
                     else if (poll_demand) st_nx = S_NEXT;
            default: st_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur_q;
        mem_wdata = '0;
        unique case (st)
            S_FETCH: begin mem_req = 1'b1; mem_addr = cur_q + AW'(widx_q); end
            S_COPY:  begin mem_req = !fifo_full; mem_addr = buf_q; end
            S_CLOSE: begin mem_req = 1'b1; mem_we = 1'b1; end
            S_STAT1: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = head;
                           mem_wdata = {1'b1, {PADW{1'b0}}, stat_q}; end
            S_STAT2: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = head;
                           mem_wdata = {1'b0, {PADW{1'b0}}, stat_q}; end
            default: ;
        endcase
        fifo_wr       = (st == S_COPY) && acc;
        fifo_data     = mem_rdata;
        fifo_sof      = fifo_wr && first_q;
        fifo_eof      = fifo_wr && last_word && ctl_q.eof;
        irq           = (st == S_SUSP);
        irq_cause_err = cause_q;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0; base_q <= '0; buf_q <= '0; link_q <= '0;
            widx_q <= '0; ctl_q <= '0; len_q <= '0; left_q <= '0;
            in_frame_q <= 1'b0; first_q <= 1'b0; done_pend_q <= 1'b0;
            ret_susp_q <= 1'b0; cause_q <= 1'b0; stat_q <= '0;
        end else begin
            case (st)
                S_IDLE: if (run) begin
                    cur_q <= list_base; base_q <= list_base; in_frame_q <= 1'b0;
                end
                S_NEXT: begin
                    widx_q <= '0;
                    ret_susp_q <= 1'b0;
                    if (done_pend_q && cnt == '0) done_pend_q <= 1'b0;
                end
                S_FETCH: if (acc) begin
                    widx_q <= widx_q + 2'd1;
                    case (widx_q)
                        2'd0: cause_q <= 1'b0;
                        2'd1: begin
                            ctl_q <= '{sof: mem_rdata[SOF_BIT], eof: mem_rdata[EOF_BIT],
                                       eor: mem_rdata[EOR_BIT], lnk: mem_rdata[LNK_BIT]};
                            len_q <= mem_rdata[LENW-1:0];
                        end
                        2'd2: buf_q  <= mem_rdata[AW-1:0];
                        default: link_q <= mem_rdata[AW-1:0];
                    endcase
                end
                S_CHECK: if (chk_err) begin
                    cause_q <= 1'b1; in_frame_q <= 1'b0;
                end else begin
                    in_frame_q <= 1'b1; left_q <= len_q; first_q <= ctl_q.sof;
                end
                S_COPY: if (acc) begin
                    buf_q <= buf_q + AW'(1);
                    left_q <= left_q - LENW'(1);
                    first_q <= 1'b0;
                    if (last_word && ctl_q.eof) begin
                        in_frame_q <= 1'b0; cur_q <= nxt_ptr;
                    end
                end
                S_CLOSE: if (acc) cur_q <= nxt_ptr;
                S_STAT2: if (acc) done_pend_q <= 1'b0;
                S_SUSP: begin
                    widx_q <= '0;
                    ret_susp_q <= 1'b1;
                    if (done_pend_q && cnt == '0) done_pend_q <= 1'b0;
                end
                default: ;
            endcase
            if (tx_done) begin
                done_pend_q <= 1'b1;
                stat_q <= tx_status;
            end
        end
    end

    a_r10_own_order: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && mem_we && mem_wdata[OWN_BIT]) |=>
        (mem_req && mem_we && !mem_wdata[OWN_BIT] && mem_addr == $past(mem_addr)
         && mem_wdata[STATW-1:0] == $past(mem_wdata[STATW-1:0])));
    a_r12_full_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !fifo_full);
    a_r4_marks_on_push: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_sof || fifo_eof) |-> fifo_wr);
    a_r3_own_suspend: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && !irq_cause_err && !$past(mem_we)) |->
        $past(mem_req && mem_gnt && !mem_rdata[OWN_BIT]));
endmodule

// File: tb/txd_engine_test.sv
module txd_engine_test;
    localparam int AW = 16;

    logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, poll_demand = 1'b0;
    logic [AW-1:0] list_base = '0;
    logic mem_req, mem_we, mem_gnt, fifo_full = 1'b0, fifo_wr, fifo_sof, fifo_eof;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata, fifo_data;
    logic tx_done = 1'b0, irq, irq_cause_err, slow = 1'b0;
    logic [15:0] tx_status = '0;

    logic [31:0] mem [0:1023];
    logic [31:0] wr_a [0:63], wr_d [0:63], f_d [0:63];
    logic f_s [0:63], f_e [0:63];
    int wr_n = 0, f_n = 0, tests = 0, fails = 0, cyc = 0;
    logic [AW-1:0] last_rd = '0;

    always #5 clk = ~clk;

    assign mem_gnt   = mem_req && (!slow || cyc[0]);
    assign mem_rdata = mem[mem_addr[9:0]];

    txd_engine uut (
        .clk(clk), .rst_n(rst_n), .run(run), .list_base(list_base),
        .poll_demand(poll_demand), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rdata(mem_rdata), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .fifo_sof(fifo_sof), .fifo_eof(fifo_eof),
        .tx_done(tx_done), .tx_status(tx_status), .irq(irq),
        .irq_cause_err(irq_cause_err));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_gnt && mem_we) begin
            mem[mem_addr[9:0]] <= mem_wdata;
            if (wr_n < 64) begin wr_a[wr_n] <= 32'(mem_addr); wr_d[wr_n] <= mem_wdata; end
            wr_n <= wr_n + 1;
        end
        if (mem_req && mem_gnt && !mem_we) last_rd <= mem_addr;
        if (fifo_wr) begin
            if (f_n < 64) begin f_d[f_n] <= fifo_data; f_s[f_n] <= fifo_sof; f_e[f_n] <= fifo_eof; end
            f_n <= f_n + 1;
        end
        if (cyc == 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(input bit sof, eof, eor, lnk, input int len);
        return {1'b0, sof, eof, 3'b0, eor, lnk, 13'b0, 11'(len)};
    endfunction

    task automatic mk(input int a, input bit own, sof, eof, eor, lnk, input int len, input int bufa, input int link);
        mem[a]   = {own, 31'b0};
        mem[a+1] = ctl(sof, eof, eor, lnk, len);
        mem[a+2] = 32'(bufa);
        mem[a+3] = 32'(link);
    endtask

    task automatic restart(input logic [AW-1:0] base);
        @(negedge clk);
        rst_n = 1'b0; run = 1'b0; slow = 1'b0; fifo_full = 1'b0; list_base = base;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        wr_n = 0; f_n = 0;
        rst_n = 1'b1;
    endtask

    task automatic go();
        @(negedge clk); run = 1'b1;
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 400 && !irq; i++) @(negedge clk);
    endtask

    task automatic done_pulse(input logic [15:0] s);
        @(negedge clk); tx_done = 1'b1; tx_status = s;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic t_reset();
        restart('0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!mem_req && !fifo_wr && !irq, "R1 idle outputs", {29'b0, mem_req, fifo_wr, irq}, 0);
        end
    endtask

    task automatic t_single();
        restart('0);
        mk(0, 1, 1, 1, 0, 0, 3, 'h100, 0);
        mem['h100] = 32'hA0; mem['h101] = 32'hA1; mem['h102] = 32'hA2;
        slow = 1'b1;
        go(); wait_irq(); @(negedge clk);
        chk(irq && !irq_cause_err, "R3 host-owned suspend", {30'b0, irq, irq_cause_err}, 2);
        chk(last_rd == 4, "R3 stopped at next desc word0", 32'(last_rd), 4);
        chk(f_n == 3, "R4 word count", f_n, 3);
        chk(f_d[0] == 'hA0 && f_d[1] == 'hA1 && f_d[2] == 'hA2, "R4 word order", f_d[2], 'hA2);
        chk(f_s[0] && !f_s[1] && !f_e[1] && f_e[2], "R4 sof/eof marks", {f_s[0], f_e[2]}, 3);
        done_pulse(16'h1234);
        repeat (12) @(negedge clk);
        chk(wr_n == 2 && wr_a[0] == 0 && wr_d[0] == 32'h8000_1234, "R10 status with own first", wr_d[0], 32'h8000_1234);
        chk(wr_a[1] == 0 && wr_d[1] == 32'h0000_1234, "R10 own released second", wr_d[1], 32'h1234);
        chk(irq, "R13 write-back while suspended", irq, 1);
    endtask

    task automatic t_chain();
        restart('0);
        mk(0, 1, 1, 0, 0, 1, 2, 'h100, 'h40);
        mk('h40, 1, 0, 1, 0, 1, 2, 'h110, 'h80);
        mem['h100] = 32'hB0; mem['h101] = 32'hB1; mem['h110] = 32'hB2; mem['h111] = 32'hB3;
        go(); wait_irq(); @(negedge clk);
        chk(f_n == 4 && f_d[2] == 'hB2 && f_d[3] == 'hB3, "R7 link followed", f_d[3], 'hB3);
        chk(last_rd == 'h80, "R7 link to third desc", 32'(last_rd), 'h80);
        chk(f_s[0] && !f_e[1] && !f_s[2] && f_e[3], "R4 multi-buffer marks", {f_s[0], f_e[1], f_s[2], f_e[3]}, 4'b1001);
        chk(wr_n == 1 && wr_a[0] == 0 && mem[0] == 0, "R5 middle desc closed", mem[0], 0);
        chk(mem['h40] == 32'h8000_0000, "R10 last desc kept until status", mem['h40], 32'h8000_0000);
    endtask

    task automatic t_ring();
        restart(16'h20);
        mk('h20, 1, 1, 1, 0, 0, 1, 'h200, 0);
        mk('h24, 1, 1, 1, 1, 0, 1, 'h210, 0);
        mem['h200] = 32'hC0; mem['h210] = 32'hC1;
        go(); repeat (60) @(negedge clk);
        chk(f_n == 2 && f_d[0] == 'hC0, "R2 fetch starts at base", f_d[0], 'hC0);
        chk(f_d[1] == 'hC1, "R9 second frame before status", f_d[1], 'hC1);
        chk(!irq && last_rd == 'h210 && wr_n == 0, "R9 third poll waits", 32'(last_rd), 'h210);
        done_pulse(16'h0055); wait_irq(); @(negedge clk);
        chk(mem['h20] == 32'h55, "R10 oldest frame closed", mem['h20], 32'h55);
        chk(irq && last_rd == 'h20, "R6 end-of-ring wraps to base", 32'(last_rd), 'h20);
        done_pulse(16'h0066); repeat (12) @(negedge clk);
        chk(mem['h24] == 32'h66 && irq, "R13 second status while suspended", mem['h24], 32'h66);
    endtask

    task automatic t_error_resume();
        restart('0);
        mk(0, 1, 0, 1, 0, 0, 1, 'h100, 0);
        mem['h100] = 32'hD0;
        go(); wait_irq(); @(negedge clk);
        chk(irq && irq_cause_err && f_n == 0, "R8 missing frame start", {31'b0, irq_cause_err}, 1);
        mem[1] = ctl(1, 1, 0, 0, 1);
        @(negedge clk); poll_demand = 1'b1; @(negedge clk); poll_demand = 1'b0;
        for (int i = 0; i < 5 && irq; i++) @(negedge clk);
        wait_irq(); @(negedge clk);
        chk(f_n == 1 && f_d[0] == 'hD0 && f_s[0] && f_e[0], "R11 resume at same desc", f_n, 1);
        chk(irq && !irq_cause_err && last_rd == 4, "R11 then ownership stop", 32'(last_rd), 4);
    endtask

    task automatic t_sof_inside();
        restart('0);
        mk(0, 1, 1, 0, 0, 0, 1, 'h100, 0);
        mk(4, 1, 1, 1, 0, 0, 1, 'h110, 0);
        go(); wait_irq(); @(negedge clk);
        chk(irq && irq_cause_err && f_n == 1, "R8 start flag inside frame", f_n, 1);
        chk(mem[0] == 0, "R5 first buffer closed", mem[0], 0);
        restart('0);
        mk(0, 1, 1, 1, 0, 0, 0, 'h100, 0);
        go(); wait_irq(); @(negedge clk);
        chk(irq && irq_cause_err && f_n == 0, "R8 zero length", {31'b0, irq_cause_err}, 1);
    endtask

    task automatic t_backpressure();
        restart('0);
        mk(0, 1, 1, 1, 0, 0, 4, 'h100, 0);
        for (int i = 0; i < 4; i++) mem['h100 + i] = 32'hE0 + 32'(i);
        fifo_full = 1'b1;
        go(); repeat (30) @(negedge clk);
        chk(f_n == 0 && last_rd == 3, "R12 no read or push while full", 32'(last_rd), 3);
        fifo_full = 1'b0; slow = 1'b1;
        wait_irq(); @(negedge clk);
        chk(f_n == 4 && f_d[0] == 'hE0 && f_d[3] == 'hE3, "R12 resumes after full", f_n, 4);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        t_reset();
        t_single();
        t_chain();
        t_ring();
        t_error_resume();
        t_sof_inside();
        t_backpressure();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule